// File: doc/BRIEF.md
# Single-Bus Microcoded Processor Datapath

This block is the datapath half of a microprogrammed 32-bit processor. Every transfer between its storage elements passes over one shared 32-bit bus. In any cycle that bus is driven by at most one of four sources: the register file, the memory read port, the ALU or the immediate generator. Four loadable latches take their value from the bus: the instruction register, the two ALU operand registers A and B, and the memory address register. The register file has 33 entries. These are 32 general registers, of which register zero always reads as zero, and the program counter, which sits in slot 32.

An external microcode sequencer drives the block through seventeen control bits, one step per cycle. In return the block gives the sequencer the opcode field of the instruction register, an operand-equality flag for branches, and a busy flag from memory. Memory is a built-in multi-cycle model. It is addressed by the address register, and it holds busy for a parameterised number of cycles before a read returns its data or a write takes effect. The bus value is also brought out as a port, so that each micro-step can be observed.

Top module: `sbus_datapath`

## Requirements
- R1: When exactly one of the drive enables is high, that source drives `bus_o`. The enables are `reg_drv`, memory read (`mem_en`=1 with `mem_wr`=0), `alu_drv` and `imm_drv`. When none of them is high, `bus_o` is zero. At most one enable is high in any cycle.
- R2: On a rising clock edge, `ld_ir`, `ld_a`, `ld_b` and `ld_ma` each capture `bus_o` into IR, A, B and MA. A latch whose strobe is low keeps its value. `opcode` is IR[6:0].
- R3: `reg_sel` picks the register index as follows. 0 gives rs1 = IR[26:22]. 1 gives rs2 = IR[21:17]. 2 gives rd = IR[31:27]. 3 gives the program counter (slot 32). 4 gives the link register (index 1). Codes 5 to 7 give index 0.
- R4: When `reg_wr` is high, the bus value is written into the selected entry on the clock edge. A write to index 0 is discarded, and index 0 always reads as zero.
- R5: Reset clears IR, A, B, MA and all general registers. It loads the program counter with `RESET_PC`, which defaults to 0.
- R6: `imm_sel` picks the immediate. 0 gives IR[21:10] sign-extended. 1 gives {IR[31:27],IR[16:10]} sign-extended and shifted left by one. 2 gives {IR[26:7], 12 zero bits}. 3 gives the constant 4.
- R7: `alu_op` picks the ALU result. 0 gives A+B. 1 gives A−B. 2 gives the jump target, A + sign-extended(B[31:7] shifted left by one). 3 gives 1 if A equals B and 0 otherwise.
- R8: `bcmp` is high exactly when A equals B, whatever `alu_op` is.
- R9: An access starts when `mem_en` rises. From that point `mem_busy` is high for exactly `MEM_LAT` cycles (default 3) and then goes low. `mem_busy` is low whenever `mem_en` is low.
- R10: During a read, memory drives zero while busy. Once busy is low it drives the word at index MA[9:2].
- R11: During a write (`mem_wr`=1), memory does not drive the bus. On the first clock edge where busy is low, it stores the bus value at word MA[9:2].
- R12: After reset, memory word i holds i·0x9E3779B1 + 0x0F1E2D3C (modulo 2^32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_ir | input | 1 | Load instruction register from bus |
| ld_a | input | 1 | Load operand A from bus |
| ld_b | input | 1 | Load operand B from bus |
| ld_ma | input | 1 | Load memory address register from bus |
| reg_sel | input | 3 | Register index selector |
| reg_wr | input | 1 | Write bus into selected register |
| reg_drv | input | 1 | Register file drives bus |
| alu_op | input | 2 | ALU operation select |
| alu_drv | input | 1 | ALU drives bus |
| imm_sel | input | 2 | Immediate format select |
| imm_drv | input | 1 | Immediate generator drives bus |
| mem_en | input | 1 | Memory access enable |
| mem_wr | input | 1 | Memory direction, 1 = write, 0 = read |
| opcode | output | 7 | IR[6:0] |
| bcmp | output | 1 | A equals B |
| mem_busy | output | 1 | Memory access in progress |
| bus_o | output | 32 | Current shared bus value |

## Verification
The bench runs the block as a sequencer would, with one micro-step per cycle. It fetches an instruction word from memory and then drives all four immediate formats from it. This tells apart field positions, sign extension and the shift in the branch format. Values are written through the rd, rs2, link and zero selectors and then read back through every selector, so that a swapped field or a kept write to register zero shows up as a wrong value. The ALU is given two operands that differ in sign and magnitude, and then two equal ones, which separates the four operations and the equality flag. Memory is checked by counting the busy cycles and by watching the bus while busy. A write is followed by reads of the written word and of an untouched word.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int XLEN     = 32;
  localparam int NREG     = 33;
  localparam int IDX_W    = 6;
  localparam int PC_IDX   = 32;
  localparam int LINK_IDX = 1;

  typedef enum logic [2:0] {
    SEL_RS1  = 3'd0,
    SEL_RS2  = 3'd1,
    SEL_RD   = 3'd2,
    SEL_PC   = 3'd3,
    SEL_LINK = 3'd4,
    SEL_Z5   = 3'd5,
    SEL_Z6   = 3'd6,
    SEL_Z7   = 3'd7
  } rsel_e;

  typedef enum logic [1:0] {
    IMM_I    = 2'd0,
    IMM_BR   = 2'd1,
    IMM_UP   = 2'd2,
    IMM_FOUR = 2'd3
  } isel_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_JTGT = 2'd2,
    OP_EQ   = 2'd3
  } aop_e;

  // Drive-enable vector bit positions; a higher bit wins on conflict.
  localparam int DRV_IMM = 0;
  localparam int DRV_ALU = 1;
  localparam int DRV_MEM = 2;
  localparam int DRV_REG = 3;
  localparam int NDRV    = 4;

  function automatic logic [IDX_W-1:0] rf_index(input rsel_e sel,
                                                input logic [XLEN-1:0] ir);
    case (sel)
      SEL_RS1:  rf_index = {1'b0, ir[26:22]};
      SEL_RS2:  rf_index = {1'b0, ir[21:17]};
      SEL_RD:   rf_index = {1'b0, ir[31:27]};
      SEL_PC:   rf_index = IDX_W'(PC_IDX);
      SEL_LINK: rf_index = IDX_W'(LINK_IDX);
      default:  rf_index = '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] imm_short(input logic [XLEN-1:0] ir);
    imm_short = {{20{ir[21]}}, ir[21:10]};
  endfunction

  function automatic logic [XLEN-1:0] imm_branch(input logic [XLEN-1:0] ir);
    imm_branch = {{19{ir[31]}}, ir[31:27], ir[16:10], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] imm_upper(input logic [XLEN-1:0] ir);
    imm_upper = {ir[26:7], 12'h000};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] a,
                                                  input logic [XLEN-1:0] b);
    jump_target = a + {{6{b[31]}}, b[31:7], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] mem_seed(input int idx);
    mem_seed = 32'(idx) * 32'h9E37_79B1 + 32'h0F1E_2D3C;
  endfunction

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rsel_e           sel,
  input  logic [XLEN-1:0] ir,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic [IDX_W-1:0] idx_o
);

  logic [XLEN-1:0] regs [NREG];
  logic [IDX_W-1:0] idx;
  logic             wr_ok;

  assign idx   = rf_index(sel, ir);
  assign idx_o = idx;
  assign wr_ok = wr && (idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        regs[i] <= (i == PC_IDX) ? RESET_PC : '0;
      end
    end else if (wr_ok) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = (idx == '0) ? '0 : regs[idx];

endmodule

// File: rtl/sbus_immgen.sv
module sbus_immgen
  import sbus_pkg::*;
(
  input  logic [XLEN-1:0] ir,
  input  isel_e           sel,
  output logic [XLEN-1:0] imm
);

  always_comb begin
    case (sel)
      IMM_I:   imm = imm_short(ir);
      IMM_BR:  imm = imm_branch(ir);
      IMM_UP:  imm = imm_upper(ir);
      default: imm = 32'd4;
    endcase
  end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  aop_e            op,
  output logic [XLEN-1:0] y,
  output logic            eq
);

  assign eq = (a == b);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_JTGT: y = jump_target(a, b);
      default: y = {{(XLEN-1){1'b0}}, eq};
    endcase
  end

endmodule

// File: rtl/sbus_mem.sv
module sbus_mem
  import sbus_pkg::*;
#(
  parameter int WORDS   = 256,
  parameter int MEM_LAT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            wr,
  input  logic [XLEN-1:0] addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic            busy,
  output logic            drive
);

  localparam int WI_W  = $clog2(WORDS);
  localparam int CNT_W = (MEM_LAT < 1) ? 1 : $clog2(MEM_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_C = CNT_W'(MEM_LAT);

  logic [XLEN-1:0]  store [WORDS];
  logic [CNT_W-1:0] cnt;
  logic [WI_W-1:0]  widx;
  logic             done;
  logic             unused_addr;

  assign widx        = addr[WI_W+1:2];
  assign unused_addr = ^{addr[XLEN-1:WI_W+2], addr[1:0]};
  assign done        = en && (cnt == LAT_C);
  assign busy        = en && !done;
  assign drive       = en && !wr;
  assign rdata       = done ? store[widx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        store[i] <= mem_seed(i);
      end
    end else if (done && wr) begin
      store[widx] <= wdata;
    end
  end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter logic [31:0] RESET_PC  = 32'h0,
  parameter int          MEM_WORDS = 256,
  parameter int          MEM_LAT   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_ir,
  input  logic        ld_a,
  input  logic        ld_b,
  input  logic        ld_ma,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_drv,
  input  logic [1:0]  alu_op,
  input  logic        alu_drv,
  input  logic [1:0]  imm_sel,
  input  logic        imm_drv,
  input  logic        mem_en,
  input  logic        mem_wr,
  output logic [6:0]  opcode,
  output logic        bcmp,
  output logic        mem_busy,
  output logic [31:0] bus_o
);

  logic [XLEN-1:0]  ir_q, a_q, b_q, ma_q;
  logic [XLEN-1:0]  bus;
  logic [XLEN-1:0]  rf_rdata, imm_val, alu_y, mem_rdata;
  logic [IDX_W-1:0] rf_idx;
  logic             mem_drive;
  logic             alu_eq;
  logic [NDRV-1:0]  drv_vec;
  logic [XLEN-1:0]  src [NDRV];

  // Named source taps and enables for the bus arbiter and the checker.
  assign drv_vec[DRV_IMM] = imm_drv;
  assign drv_vec[DRV_ALU] = alu_drv;
  assign drv_vec[DRV_MEM] = mem_drive;
  assign drv_vec[DRV_REG] = reg_drv;
  assign src[DRV_IMM]     = imm_val;
  assign src[DRV_ALU]     = alu_y;
  assign src[DRV_MEM]     = mem_rdata;
  assign src[DRV_REG]     = rf_rdata;

  always_comb begin
    bus = '0;
    for (int k = 0; k < NDRV; k++) begin
      if (drv_vec[k]) bus = src[k];
    end
  end

  assign bus_o = bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir) ir_q <= bus;
      if (ld_a)  a_q  <= bus;
      if (ld_b)  b_q  <= bus;
      if (ld_ma) ma_q <= bus;
    end
  end

  sbus_regfile #(.RESET_PC(RESET_PC)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (rsel_e'(reg_sel)),
    .ir    (ir_q),
    .wr    (reg_wr),
    .wdata (bus),
    .rdata (rf_rdata),
    .idx_o (rf_idx)
  );

  sbus_immgen u_imm (
    .ir  (ir_q),
    .sel (isel_e'(imm_sel)),
    .imm (imm_val)
  );

  sbus_alu u_alu (
    .a  (a_q),
    .b  (b_q),
    .op (aop_e'(alu_op)),
    .y  (alu_y),
    .eq (alu_eq)
  );

  sbus_mem #(.WORDS(MEM_WORDS), .MEM_LAT(MEM_LAT)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mem_en),
    .wr    (mem_wr),
    .addr  (ma_q),
    .wdata (bus),
    .rdata (mem_rdata),
    .busy  (mem_busy),
    .drive (mem_drive)
  );

  assign opcode = ir_q[6:0];
  assign bcmp   = alu_eq;

endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int MEM_LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  drv_vec,
  input logic        reg_drv,
  input logic [5:0]  rf_idx,
  input logic        ld_a,
  input logic        ld_ir,
  input logic [31:0] a_q,
  input logic [6:0]  opcode,
  input logic        mem_en,
  input logic        mem_wr,
  input logic        mem_busy,
  input logic [31:0] bus_o
);

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_vec)); // R1

  AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> (a_q == $past(bus_o))); // R2

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ir |=> $stable(opcode)); // R2

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_drv && rf_idx == 6'd0) |-> (bus_o == 32'd0)); // R4

  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |-> !mem_busy); // R9

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((MEM_LAT > 0) && $rose(mem_en)) |-> mem_busy); // R9

  AST_READ_ZERO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_wr && mem_busy && !reg_drv && drv_vec[1:0] == 2'b00)
      |-> (bus_o == 32'd0)); // R10

endmodule

bind sbus_datapath sbus_datapath_chk #(.MEM_LAT(MEM_LAT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drv_vec  (drv_vec),
  .reg_drv  (reg_drv),
  .rf_idx   (rf_idx),
  .ld_a     (ld_a),
  .ld_ir    (ld_ir),
  .a_q      (a_q),
  .opcode   (opcode),
  .mem_en   (mem_en),
  .mem_wr   (mem_wr),
  .mem_busy (mem_busy),
  .bus_o    (bus_o)
);

// File: tb/sbus_datapath_tb.sv
module sbus_datapath_tb;

  localparam int LAT = 3;
  localparam logic [31:0] RPC = 32'h0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_ir = 0, ld_a = 0, ld_b = 0, ld_ma = 0;
  logic [2:0] reg_sel = 0;
  logic reg_wr = 0, reg_drv = 0;
  logic [1:0] alu_op = 0;
  logic alu_drv = 0;
  logic [1:0] imm_sel = 0;
  logic imm_drv = 0, mem_en = 0, mem_wr = 0;
  logic [6:0] opcode;
  logic bcmp, mem_busy;
  logic [31:0] bus_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench shadow state
  logic [31:0] s_ir = 0, s_a = 0, s_b = 0;
  logic [31:0] s_rf [33];

  always #2 clk = ~clk;

  sbus_datapath #(.RESET_PC(RPC), .MEM_WORDS(256), .MEM_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b),
    .ld_ma(ld_ma), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_drv(reg_drv),
    .alu_op(alu_op), .alu_drv(alu_drv), .imm_sel(imm_sel), .imm_drv(imm_drv),
    .mem_en(mem_en), .mem_wr(mem_wr), .opcode(opcode), .bcmp(bcmp),
    .mem_busy(mem_busy), .bus_o(bus_o)
  );

  function automatic logic [31:0] seed_word(input int i);
    logic [63:0] p;
    p = 64'(i) * 64'h9E37_79B1 + 64'h0F1E_2D3C;
    return p[31:0];
  endfunction

  function automatic logic [31:0] exp_imm(input int s, input logic [31:0] ir);
    int v;
    case (s)
      0: begin v = int'(ir[21:10]); if (ir[21]) v = v - 4096; end
      1: begin v = int'({ir[31:27], ir[16:10]}); if (ir[31]) v = v - 4096; v = v * 2; end
      2: v = int'(ir[26:7]) * 4096;
      default: v = 4;
    endcase
    return 32'(v);
  endfunction

  function automatic int sel_index(input int s, input logic [31:0] ir);
    case (s)
      0: return int'(ir[26:22]);
      1: return int'(ir[21:17]);
      2: return int'(ir[31:27]);
      3: return 32;
      4: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_alu(input int op, input logic [31:0] a,
                                          input logic [31:0] b);
    longint off;
    case (op)
      0: return a + b;
      1: return a + (~b) + 32'd1;
      2: begin
        off = longint'(b >> 7);
        if (b[31]) off = off - (longint'(1) << 25);
        return a + 32'(off * 2);
      end
      default: return (a ^ b) == 0 ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ld_ir = 0; ld_a = 0; ld_b = 0; ld_ma = 0; reg_sel = 0; reg_wr = 0;
    reg_drv = 0; alu_op = 0; alu_drv = 0; imm_sel = 0; imm_drv = 0;
    mem_en = 0; mem_wr = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  // drive the immediate and write it into register selector s
  task automatic write_imm_to(input int isel, input int s);
    imm_drv = 1; imm_sel = 2'(isel); reg_wr = 1; reg_sel = 3'(s);
    if (sel_index(s, s_ir) != 0) s_rf[sel_index(s, s_ir)] = exp_imm(isel, s_ir);
    step();
  endtask

  task automatic read_reg(input string req, input int s);
    reg_drv = 1; reg_sel = 3'(s);
    #1 chk(req, bus_o, s_rf[sel_index(s, s_ir)]);
    step();
  endtask

  // memory read; tgt: 0 IR, 1 A, 2 B
  task automatic mem_read(input string req, input logic [31:0] expv, input int tgt);
    int nb = 0;
    mem_en = 1; mem_wr = 0;
    #1;
    while (mem_busy && nb < 20) begin
      chk("R10 bus zero while busy", bus_o, 32'd0);
      nb++;
      @(posedge clk); @(negedge clk); #1;
    end
    chk("R9 busy cycle count", 32'(nb), 32'(LAT));
    chk(req, bus_o, expv);
    case (tgt)
      0: begin ld_ir = 1; s_ir = bus_o; end
      1: begin ld_a = 1; s_a = bus_o; end
      default: begin ld_b = 1; s_b = bus_o; end
    endcase
    step();
    step();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 undriven bus zero", bus_o, 32'd0);
    chk("R5 opcode after reset", 32'(opcode), 32'd0);
    chk("R9 idle not busy", 32'(mem_busy), 32'd0);
    chk("R8 bcmp with A=B=0", 32'(bcmp), 32'd1);
    read_reg("R5 reset PC", 3);
    read_reg("R5 reset rs1 reg", 0);
  endtask

  task automatic t_fetch();
    mem_read("R12 word0 seed value", seed_word(0), 0);
    #1 chk("R2 opcode from IR", 32'(opcode), 32'(s_ir[6:0]));
  endtask

  task automatic t_imm();
    for (int k = 0; k < 4; k++) begin
      imm_drv = 1; imm_sel = 2'(k);
      #1 chk($sformatf("R6 immediate format %0d", k), bus_o, exp_imm(k, s_ir));
      step();
    end
  endtask

  task automatic t_regs();
    write_imm_to(3, 4);           // link <- 4
    read_reg("R3 link readback", 4);
    write_imm_to(2, 2);           // rd <- upper
    write_imm_to(1, 1);           // rs2 <- branch imm
    read_reg("R3 rd select", 2);
    read_reg("R3 rs2 select", 1);
    read_reg("R3 rs1 select", 0);
    read_reg("R3 link after rd write", 4);
    write_imm_to(3, 5);           // index 0 write discarded
    read_reg("R4 zero register stays zero", 5);
    read_reg("R4 zero via code 7", 7);
  endtask

  task automatic t_pc();
    reg_drv = 1; reg_sel = 3; ld_a = 1; s_a = s_rf[32]; step();
    imm_drv = 1; imm_sel = 3; ld_b = 1; s_b = 32'd4; step();
    alu_drv = 1; alu_op = 0; reg_wr = 1; reg_sel = 3;
    s_rf[32] = exp_alu(0, s_a, s_b); step();
    read_reg("R3 PC slot increment", 3);
    chk("R3 PC value", s_rf[32], RPC + 32'd4);
  endtask

  task automatic t_alu();
    imm_drv = 1; imm_sel = 2; ld_a = 1; s_a = exp_imm(2, s_ir); step();
    imm_drv = 1; imm_sel = 0; ld_b = 1; s_b = exp_imm(0, s_ir); step();
    for (int k = 0; k < 4; k++) begin
      alu_drv = 1; alu_op = 2'(k);
      #1 chk($sformatf("R7 alu op %0d", k), bus_o, exp_alu(k, s_a, s_b));
      step();
    end
    #1 chk("R8 bcmp unequal", 32'(bcmp), (s_a == s_b) ? 32'd1 : 32'd0);
    imm_drv = 1; imm_sel = 2; ld_b = 1; s_b = exp_imm(2, s_ir); step();
    #1 chk("R8 bcmp equal", 32'(bcmp), 32'd1);
    alu_drv = 1; alu_op = 3;
    #1 chk("R7 eq op equal", bus_o, 32'd1);
    step();
  endtask

  task automatic t_mem_write();
    logic [31:0] v;
    int nb = 0;
    imm_drv = 1; imm_sel = 1; ld_b = 1; s_b = exp_imm(1, s_ir); step();
    imm_drv = 1; imm_sel = 3; ld_ma = 1; step();      // MA = 4 -> word 1
    v = exp_alu(0, s_a, s_b);
    mem_en = 1; mem_wr = 1; alu_drv = 1; alu_op = 0;
    #1;
    while (mem_busy && nb < 20) begin
      nb++;
      @(posedge clk); @(negedge clk); #1;
    end
    chk("R11 write busy count", 32'(nb), 32'(LAT));
    chk("R11 memory not driving on write", bus_o, v);
    step();
    step();
    mem_read("R11 written word read back", v, 1);
    reg_drv = 1; reg_sel = 5; ld_ma = 1; step();     // MA = 0
    mem_read("R12 untouched word0", seed_word(0), 2);
  endtask

  initial begin
    for (int i = 0; i < 33; i++) s_rf[i] = 0;
    s_rf[32] = RPC;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fetch();
    t_imm();
    t_regs();
    t_pc();
    t_alu();
    t_mem_write();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule